// File: doc/BRIEF.md
# Per-Task Laxity Tracking Cell

One instance of this cell stands for one task inside a scheduling coprocessor. The host writes the task's worst-case computation budget and its relative deadline into the cell. Both values are counted in time-base ticks. A host command then arms the task. The cell keeps two live counters: the time left until the deadline and the computation time left. These counters step down by one on the time-base tick. The deadline counter moves for every task that is not suspended. The computation counter moves only while the task is running.

The cell presents the signed difference of the two counters as the task's slack, one bit wider than the parameters. A shared selector, outside this block, compares the slack of all cells. The cell also drives an eligibility flag, which tells the selector whether the task may compete. A sticky miss flag records that the slack has gone negative, which means the task cannot meet its deadline. Host commands move the task through four states: suspended, waiting, ready and running.

Top module: `laxity_cell`

## Requirements
- R1: After reset the state is suspended (code 2'b00), the slack is 0, and both eligible and miss are low.
- R2: A write with wr_sel=0 stores the computation budget and a write with wr_sel=1 stores the deadline. A write alone leaves the live counters, and therefore the slack, unchanged.
- R3: Command op 4 (reload) loads the deadline counter from the stored deadline and the computation counter from the stored budget, and sets the state to ready. It takes priority over a tick in the same cycle. It uses the stored values as they were before any write in that same cycle.
- R4: On a tick the deadline counter decreases by one in every state except suspended. It stops at zero.
- R5: On a tick the computation counter decreases by one only in the running state. It stops at zero.
- R6: The slack output equals the deadline counter minus the computation counter, as a 17-bit two's-complement value. It reflects the counters in the same cycle that they change.
- R7: Miss rises in the cycle after the slack is observed negative. It stays high until a reload clears it at the reload edge.
- R8: The state codes are 00 suspended, 01 waiting, 10 ready and 11 running. Op 0 (suspend) and op 1 (wait) are accepted from any state. Op 2 (ready) is accepted only from waiting or running. Op 3 (run) is accepted only from ready. Ops 5 to 7 have no effect.
- R9: Eligible is high exactly when the state is ready or running.
- R10: A command takes effect at the clock edge. A tick in the same cycle as a command is applied according to the state before that command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Parameter write strobe |
| wr_sel | input | 1 | 0: computation budget, 1: deadline |
| wr_data | input | 16 | Parameter value in ticks |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 suspend, 1 wait, 2 ready, 3 run, 4 reload) |
| tick | input | 1 | Time-base tick, one clock wide |
| state | output | 2 | Current task state |
| slack | output | 17 | Signed slack, deadline left minus computation left |
| eligible | output | 1 | Task may compete in the selector |
| miss | output | 1 | Sticky flag: slack has been negative |

## Verification
Slack is the only view of the two counters, so the cases are built to separate them. A ready task whose slack does not shrink on a tick points to a stuck deadline counter. A running task whose slack moves points to a wrong computation counter. Either fault appears on the slack in the cycle right after the tick. A wrong state register appears at once on the state and eligible outputs. It also appears one tick later as a wrong slack step. A bad miss update is exposed the cycle after a negative slack, or at a reload. Every cycle is compared against a behavioural model, so each of these errors is caught within one clock.

// File: rtl/laxity_pkg.sv
package laxity_pkg;
  typedef enum logic [1:0] {
    ST_SUSP  = 2'b00,
    ST_WAIT  = 2'b01,
    ST_READY = 2'b10,
    ST_RUN   = 2'b11
  } task_state_t;

  localparam logic [2:0] OP_SUSPEND = 3'd0;
  localparam logic [2:0] OP_WAIT    = 3'd1;
  localparam logic [2:0] OP_READY   = 3'd2;
  localparam logic [2:0] OP_RUN     = 3'd3;
  localparam logic [2:0] OP_RELOAD  = 3'd4;
endpackage

// File: rtl/laxity_param_regs.sv
module laxity_param_regs #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] c_cfg,
  output logic [PW-1:0] d_cfg
);
  logic [PW-1:0] c_d, d_d;
  logic          c_en, d_en;

  always_comb begin
    c_en = wr_en && !wr_sel;
    d_en = wr_en && wr_sel;
    c_d  = c_en ? wr_data : c_cfg;
    d_d  = d_en ? wr_data : d_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_cfg <= '0;
      d_cfg <= '0;
    end else begin
      c_cfg <= c_d;
      d_cfg <= d_d;
    end
  end

  // R2: a write to one field leaves the other field untouched
  assert_field_isolation_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> $stable(d_cfg));
endmodule

// File: rtl/laxity_state_reg.sv
module laxity_state_reg
  import laxity_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  output task_state_t st_q,
  output logic        reload
);
  task_state_t st_d;

  always_comb begin
    reload = cmd_valid && (cmd_op == OP_RELOAD);
    st_d   = st_q;
    if (cmd_valid) begin
      case (cmd_op)
        OP_SUSPEND: st_d = ST_SUSP;
        OP_WAIT:    st_d = ST_WAIT;
        OP_READY:   if (st_q == ST_WAIT || st_q == ST_RUN) st_d = ST_READY;
        OP_RUN:     if (st_q == ST_READY) st_d = ST_RUN;
        OP_RELOAD:  st_d = ST_READY;
        default:    st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_SUSP;
    else        st_q <= st_d;
  end

  // R8: a run command outside ready or running leaves the state alone
  assert_run_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RUN && st_q != ST_READY && st_q != ST_RUN)
    |=> (st_q == $past(st_q)));

  // R3: reload always lands in ready
  assert_reload_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (st_q == ST_READY));
endmodule

// File: rtl/laxity_down_counter.sv
module laxity_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic [W-1:0] count
);
  logic [W-1:0] count_d;
  logic         at_floor;

  always_comb begin
    at_floor = (count == '0);
    if (load)                   count_d = load_val;
    else if (dec_en && !at_floor) count_d = count - 1'b1;
    else                        count_d = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  // R4 (deadline instance) and R5 (computation instance): one step per enabled tick
  assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && !load && count != '0) |=> (count == $past(count) - 1'b1));

  // R5: without enable or load the counter holds, including at zero
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (!dec_en || count == '0)) |=> $stable(count));
endmodule

// File: rtl/laxity_cell.sv
module laxity_cell
  import laxity_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [PW-1:0] wr_data,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          tick,
  output logic [1:0]    state,
  output logic [PW:0]   slack,
  output logic          eligible,
  output logic          miss
);
  localparam int SW = PW + 1;

  logic          rst_meta, rst_int_n;
  logic [PW-1:0] c_cfg, d_cfg;
  logic [PW-1:0] rem_d, rem_c;
  logic          reload;
  task_state_t   st;
  logic          d_dec, c_dec;
  logic          slack_neg;
  logic          miss_d;
  logic [SW-1:0] slack_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  laxity_param_regs #(.PW(PW)) u_params (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .c_cfg(c_cfg), .d_cfg(d_cfg)
  );

  laxity_state_reg u_state (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .st_q(st), .reload(reload)
  );

  always_comb begin
    d_dec = tick && (st != ST_SUSP);
    c_dec = tick && (st == ST_RUN);
  end

  laxity_down_counter #(.W(PW)) u_dl_cnt (
    .clk(clk), .rst_n(rst_int_n), .load(reload), .load_val(d_cfg),
    .dec_en(d_dec), .count(rem_d)
  );

  laxity_down_counter #(.W(PW)) u_ct_cnt (
    .clk(clk), .rst_n(rst_int_n), .load(reload), .load_val(c_cfg),
    .dec_en(c_dec), .count(rem_c)
  );

  always_comb begin
    slack_w   = $signed({1'b0, rem_d}) - $signed({1'b0, rem_c});
    slack_neg = slack_w[SW-1];
    miss_d    = reload ? 1'b0 : (miss | slack_neg);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) miss <= 1'b0;
    else            miss <= miss_d;
  end

  assign slack    = slack_w;
  assign state    = st;
  assign eligible = (st == ST_READY) || (st == ST_RUN);

  // R7: once set, miss survives every cycle without a reload
  assert_miss_sticky_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (miss && !reload) |=> miss);

  // R7: a negative slack is flagged by the following cycle
  assert_miss_follows_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (slack_neg && !reload) |=> miss);

  // R6: a running task at nonzero counters keeps its slack across a tick
  assert_run_slack_flat_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tick && st == ST_RUN && !cmd_valid && rem_d != '0 && rem_c != '0) |=> $stable(slack_w));
endmodule

// File: tb/laxity_cell_test.sv
module laxity_cell_test;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, wr_sel = 1'b0;
  logic [PW-1:0] wr_data = '0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic          tick = 1'b0;
  logic [1:0]    state;
  logic [PW:0]   slack;
  logic          eligible, miss;

  int checks = 0, failures = 0;
  bit done = 0, cmp_on = 0;

  int md, mc, mC, mD, mst, mmiss;

  always #10 clk = ~clk;

  laxity_cell #(.PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .tick(tick),
    .state(state), .slack(slack), .eligible(eligible), .miss(miss)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      md = 0; mc = 0; mC = 0; mD = 0; mst = 0; mmiss = 0;
    end else begin
      int nmiss, nst;
      bit rl;
      rl = cmd_valid && cmd_op == 3'd4;
      nmiss = rl ? 0 : ((mmiss != 0 || (md - mc) < 0) ? 1 : 0);
      nst = mst;
      if (cmd_valid) begin
        if (cmd_op == 3'd0) nst = 0;
        else if (cmd_op == 3'd1) nst = 1;
        else if (cmd_op == 3'd2 && (mst == 1 || mst == 3)) nst = 2;
        else if (cmd_op == 3'd3 && mst == 2) nst = 3;
        else if (cmd_op == 3'd4) nst = 2;
      end
      if (rl) begin
        md = mD; mc = mC;
      end else if (tick) begin
        if (mst != 0 && md > 0) md = md - 1;
        if (mst == 3 && mc > 0) mc = mc - 1;
      end
      if (wr_en && !wr_sel) mC = int'(wr_data);
      if (wr_en && wr_sel)  mD = int'(wr_data);
      mst = nst; mmiss = nmiss;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R6", "model slack", int'($signed(slack)), md - mc);
      check("R8", "model state", int'(state), mst);
      check("R9", "model eligible", int'(eligible), (mst >= 2) ? 1 : 0);
      check("R7", "model miss", int'(miss), mmiss);
    end
  end

  task automatic cyc(bit we, bit ws, int d, bit cv, int op, bit tk);
    wr_en = we; wr_sel = ws; wr_data = PW'(d);
    cmd_valid = cv; cmd_op = 3'(op); tick = tk;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; wr_sel = 0; cmd_valid = 0; cmd_op = 0; tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;
    // R1 reset state
    check("R1", "state", int'(state), 0);
    check("R1", "slack", int'($signed(slack)), 0);
    check("R1", "eligible", int'(eligible), 0);
    check("R1", "miss", int'(miss), 0);
    // R2 writes do not touch counters
    cyc(1, 0, 3, 0, 0, 0);
    cyc(1, 1, 10, 0, 0, 0);
    check("R2", "slack after writes", int'($signed(slack)), 0);
    // R4 suspended task does not count
    cyc(0, 0, 0, 0, 0, 1);
    check("R4", "slack suspended tick", int'($signed(slack)), 0);
    // R3 reload
    cyc(0, 0, 0, 1, 4, 0);
    check("R3", "slack after reload", int'($signed(slack)), 7);
    check("R3", "state after reload", int'(state), 2);
    check("R9", "eligible ready", int'(eligible), 1);
    // R4 ready tick
    cyc(0, 0, 0, 0, 0, 1);
    check("R4", "slack ready tick", int'($signed(slack)), 6);
    // R10 run command with tick: tick applied as ready
    cyc(0, 0, 0, 1, 3, 1);
    check("R10", "slack run+tick", int'($signed(slack)), 5);
    check("R10", "state run", int'(state), 3);
    // R5 running tick keeps slack
    cyc(0, 0, 0, 0, 0, 1);
    check("R5", "slack running tick", int'($signed(slack)), 5);
    // R8/R9 wait
    cyc(0, 0, 0, 1, 1, 0);
    check("R9", "eligible waiting", int'(eligible), 0);
    cyc(0, 0, 0, 0, 0, 1);
    check("R4", "slack waiting tick", int'($signed(slack)), 4);
    cyc(0, 0, 0, 1, 3, 0);
    check("R8", "run from waiting ignored", int'(state), 1);
    cyc(0, 0, 0, 1, 2, 0);
    check("R8", "ready from waiting", int'(state), 2);
    cyc(0, 0, 0, 1, 7, 0);
    check("R8", "op 7 ignored", int'(state), 2);
    // R3 reload wins over tick and uses pre-write deadline
    cyc(1, 0, 20, 0, 0, 0);
    cyc(1, 1, 5, 1, 4, 1);
    check("R3", "slack reload+write+tick", int'($signed(slack)), -10);
    check("R7", "miss clear at reload", int'(miss), 0);
    cyc(0, 0, 0, 0, 0, 0);
    check("R7", "miss rises", int'(miss), 1);
    // R4 deadline floor
    for (int i = 0; i < 13; i++) cyc(0, 0, 0, 0, 0, 1);
    check("R4", "deadline floor slack", int'($signed(slack)), -20);
    // R5 computation floor
    cyc(0, 0, 0, 1, 3, 0);
    for (int i = 0; i < 25; i++) cyc(0, 0, 0, 0, 0, 1);
    check("R5", "computation floor slack", int'($signed(slack)), 0);
    check("R7", "miss sticky", int'(miss), 1);
    // R3 reload with new deadline, R7 clear then set again
    cyc(0, 0, 0, 1, 4, 0);
    check("R3", "slack reload 5-20", int'($signed(slack)), -15);
    check("R7", "miss cleared", int'(miss), 0);
    cyc(0, 0, 0, 1, 0, 1);
    check("R8", "suspend", int'(state), 0);
    check("R7", "miss set again", int'(miss), 1);
    // mixed stimulus against the model
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 9);
      cyc(r == 0, $urandom_range(0, 1) == 1, $urandom_range(0, 40),
          r >= 6, $urandom_range(0, 7), $urandom_range(0, 2) != 0);
    end
    finish_run();
  end
endmodule